// File: doc/BRIEF.md
# Five-Band Equalizer Control Slave

This block is the control front end of a stereo five-band graphic equalizer. It listens on a two-wire serial bus (SCL and SDA), answers to one of two write addresses picked by a strap pin, and keeps one setting register for each band. Each register holds a boost step and a cut step. One register for each band serves the left and the right channel alike. Band 1's register also carries a global defeat flag.

A bus master writes a subaddress and then one or more data bytes. The subaddress advances after every data byte, so all five bands can be loaded in one transfer. The block decodes each 3-bit code into a step from 0 to 5 and drives the results as registered outputs to the analog or DSP filter network. Setting defeat forces every band to report step 0 for both boost and cut. The stored settings are kept and come back when defeat is cleared.

The bus inputs are sampled with two-flop synchronisers on the system clock. The block only ever pulls SDA low. It does so on the acknowledge bit of each byte it accepts.

Top module: `eq_ctrl_slave`

## Requirements
- R1: With `addr_sel_i` low the block acknowledges the address byte 0x84; with `addr_sel_i` high it acknowledges 0x86. Acknowledge means `sda_pull_o` is 1 while SCL is high during the ninth bit.
- R2: An address byte that does not match, or one with bit 0 = 1 (read), is not acknowledged. Every later byte up to the next START is also not acknowledged and changes no output.
- R3: After a matching address, the subaddress byte and each data byte are acknowledged. Subaddress k (0 to 4) selects band k+1. In a data byte, bits 6:4 are the boost code and bits 2:0 are the cut code. Bit 7 is the defeat flag when the subaddress is 0 and is ignored otherwise; bit 3 is always ignored.
- R4: Each further data byte in the same transfer goes to the next subaddress (auto-increment).
- R5: A data byte aimed at a subaddress above 4, whether written directly or reached by auto-increment, is acknowledged but changes no output.
- R6: Codes 0 to 4 decode to steps 0 to 4; codes 5, 6 and 7 all decode to step 5. Band n's step sits at bits [3(n-1)+2 : 3(n-1)] of `band_boost_o` and of `band_cut_o`.
- R7: While defeat is 1, every band reports step 0 on both outputs. When defeat returns to 0, the stored boost and cut steps reappear unchanged.
- R8: After reset, `defeat_o` is 1, every stored code and every output step is 0, and SDA is released.
- R9: A STOP that arrives before the eighth bit of a data byte leaves every output unchanged.
- R10: A START at any point, including in the middle of a byte, restarts address reception, and the block keeps working without a STOP in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel_i | input | 1 | Address select strap: 0 selects 0x84, 1 selects 0x86 |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| band_boost_o | output | 15 | Decoded boost step of each band, 3 bits per band, band 1 in the low bits |
| band_cut_o | output | 15 | Decoded cut step of each band, 3 bits per band, band 1 in the low bits |
| defeat_o | output | 1 | Global defeat flag |

## Verification
A wrong byte phase or bit count shows at the ports within one bus bit: acknowledges appear on the wrong bytes or fail to appear. Every acknowledge is checked while SCL is high. A wrong subaddress pointer, write strobe or stored code shows on the band outputs a few system clocks after the acknowledge of the byte concerned. The outputs are compared with a reference model on every clock between transfers, and also throughout transfers that must be ignored. A stored value lost under defeat only shows when defeat is cleared, so the bench clears it and compares every band again.

// File: rtl/eq_ctrl_pkg.sv
package eq_ctrl_pkg;

  localparam int unsigned BANDS_DEF    = 5;
  localparam int unsigned STEP_W_DEF   = 3;
  localparam int unsigned MAX_STEP_DEF = 5;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_IGNORE
  } bus_phase_t;

  // saturate a raw control code at the top step
  function automatic logic [STEP_W_DEF-1:0] sat_step(input logic [STEP_W_DEF-1:0] code,
                                                     input int unsigned max_step);
    if (int'(code) > int'(max_step)) return STEP_W_DEF'(max_step);
    return code;
  endfunction

endpackage

// File: rtl/eq_line_sync.sv
module eq_line_sync #(
  parameter int unsigned WIDTH     = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/eq_byte_engine.sv
module eq_byte_engine
  import eq_ctrl_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h42,
  parameter int unsigned SUB_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             sel_s,
  output logic             pull_o,
  output logic             wr_en_o,
  output logic [SUB_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o
);

  localparam logic [3:0]       LAST_BIT = 4'd8;
  localparam logic [SUB_W-1:0] SUB_TOP  = '1;

  logic scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  bus_phase_t       phase;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             in_ack;
  logic             pull_q;
  logic [SUB_W-1:0] sub_ptr;
  logic [7:0]       own_wr_byte;
  logic             receiving;

  assign own_wr_byte = {BASE_ADDR[6:1], sel_s, 1'b0};
  assign receiving   = (phase == PH_ADDR) || (phase == PH_SUB) || (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      in_ack    <= 1'b0;
      pull_q    <= 1'b0;
      sub_ptr   <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_det) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        pull_q  <= 1'b0;
      end else if (start_det) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        pull_q  <= 1'b0;
      end else if (receiving) begin
        if (scl_rise && !in_ack && bit_cnt < LAST_BIT) begin
          shreg   <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack  <= 1'b0;
            pull_q  <= 1'b0;
            bit_cnt <= '0;
          end else if (bit_cnt == LAST_BIT) begin
            unique case (phase)
              PH_ADDR: begin
                if (shreg == own_wr_byte) begin
                  in_ack <= 1'b1;
                  pull_q <= 1'b1;
                  phase  <= PH_SUB;
                end else begin
                  pull_q <= 1'b0;
                  phase  <= PH_IGNORE;
                end
              end
              PH_SUB: begin
                in_ack  <= 1'b1;
                pull_q  <= 1'b1;
                sub_ptr <= shreg[SUB_W-1:0];
                phase   <= PH_DATA;
              end
              default: begin
                in_ack    <= 1'b1;
                pull_q    <= 1'b1;
                wr_en_o   <= 1'b1;
                wr_addr_o <= sub_ptr;
                wr_data_o <= shreg;
                if (sub_ptr != SUB_TOP) sub_ptr <= sub_ptr + 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  assign pull_o = pull_q;

  // R2
  ignore_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE) |-> !pull_q);

  // R3
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_q) |-> $past(scl_fall));

  // R4
  strobe_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (phase == PH_DATA && pull_q));

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phase == PH_IDLE && !pull_q && !wr_en_o));

  // R10
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> (phase == PH_ADDR && bit_cnt == 4'd0 && !pull_q));

endmodule

// File: rtl/eq_band_regs.sv
module eq_band_regs
  import eq_ctrl_pkg::*;
#(
  parameter int unsigned BANDS    = BANDS_DEF,
  parameter int unsigned STEP_W   = STEP_W_DEF,
  parameter int unsigned MAX_STEP = MAX_STEP_DEF,
  parameter int unsigned SUB_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SUB_W-1:0]        wr_addr,
  input  logic [7:0]              wr_data,
  output logic [BANDS*STEP_W-1:0] boost_o,
  output logic [BANDS*STEP_W-1:0] cut_o,
  output logic                    defeat_o
);

  localparam int unsigned BOOST_LSB = 4;
  localparam int unsigned CUT_LSB   = 0;
  localparam int unsigned DEF_BIT   = 7;

  logic [STEP_W-1:0] boost_q [BANDS];
  logic [STEP_W-1:0] cut_q   [BANDS];
  logic              def_q;
  logic              unused_bits;

  assign unused_bits = wr_data[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      def_q <= 1'b1;
    end else if (wr_en && wr_addr == '0) begin
      def_q <= wr_data[DEF_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) defeat_o <= 1'b1;
    else     defeat_o <= def_q;
  end

  for (genvar b = 0; b < BANDS; b++) begin : g_band
    always_ff @(posedge clk) begin
      if (rst) begin
        boost_q[b] <= '0;
        cut_q[b]   <= '0;
      end else if (wr_en && wr_addr == SUB_W'(b)) begin
        boost_q[b] <= wr_data[BOOST_LSB +: STEP_W];
        cut_q[b]   <= wr_data[CUT_LSB +: STEP_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst || def_q) begin
        boost_o[b*STEP_W +: STEP_W] <= '0;
        cut_o[b*STEP_W +: STEP_W]   <= '0;
      end else begin
        boost_o[b*STEP_W +: STEP_W] <= sat_step(boost_q[b], MAX_STEP);
        cut_o[b*STEP_W +: STEP_W]   <= sat_step(cut_q[b], MAX_STEP);
      end
    end

    // R6
    step_limit_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(boost_o[b*STEP_W +: STEP_W]) <= int'(MAX_STEP)) &&
      (int'(cut_o[b*STEP_W +: STEP_W]) <= int'(MAX_STEP)));

    // R5
    far_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && int'(wr_addr) >= int'(BANDS)) |=> ($stable(boost_q[b]) && $stable(cut_q[b])));
  end

  // R7
  defeat_flat_chk: assert property (@(posedge clk) disable iff (rst)
    defeat_o |-> (boost_o == '0 && cut_o == '0));

  // R8
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (defeat_o && boost_o == '0 && cut_o == '0));

endmodule

// File: rtl/eq_ctrl_slave.sv
module eq_ctrl_slave
  import eq_ctrl_pkg::*;
#(
  parameter int unsigned BANDS     = BANDS_DEF,
  parameter int unsigned STEP_W    = STEP_W_DEF,
  parameter int unsigned MAX_STEP  = MAX_STEP_DEF,
  parameter logic [6:0]  BASE_ADDR = 7'h42
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic                    addr_sel_i,
  output logic                    sda_pull_o,
  output logic [BANDS*STEP_W-1:0] band_boost_o,
  output logic [BANDS*STEP_W-1:0] band_cut_o,
  output logic                    defeat_o
);

  localparam int unsigned SUB_W   = 8;
  localparam int unsigned N_LINES = 3;

  logic [N_LINES-1:0] lines_s;
  logic               wr_en;
  logic [SUB_W-1:0]   wr_addr;
  logic [7:0]         wr_data;

  eq_line_sync #(
    .WIDTH   (N_LINES),
    .RST_VAL ({N_LINES{1'b1}})
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({addr_sel_i, sda_i, scl_i}),
    .sync_o  (lines_s)
  );

  eq_byte_engine #(
    .BASE_ADDR (BASE_ADDR),
    .SUB_W     (SUB_W)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (lines_s[0]),
    .sda_s     (lines_s[1]),
    .sel_s     (lines_s[2]),
    .pull_o    (sda_pull_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  eq_band_regs #(
    .BANDS    (BANDS),
    .STEP_W   (STEP_W),
    .MAX_STEP (MAX_STEP),
    .SUB_W    (SUB_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .boost_o  (band_boost_o),
    .cut_o    (band_cut_o),
    .defeat_o (defeat_o)
  );

endmodule

// File: tb/eq_ctrl_slave_test.sv
`timescale 1ns/1ps
module eq_ctrl_slave_test;

  localparam int NB   = 5;
  localparam int SW   = 3;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sel = 1'b0;
  logic sda_pull;
  logic sda_bus;
  logic [NB*SW-1:0] boost, cut;
  logic defeat;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  eq_ctrl_slave uut (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .addr_sel_i   (sel),
    .sda_pull_o   (sda_pull),
    .band_boost_o (boost),
    .band_cut_o   (cut),
    .defeat_o     (defeat)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  int boost_m[NB];
  int cut_m[NB];
  bit def_m;
  logic [7:0] pay[8];

  function automatic int sat(input int c);
    return (c > 4) ? 5 : c;
  endfunction

  function automatic logic [NB*SW-1:0] exp_vec(input bit is_cut);
    logic [NB*SW-1:0] v;
    v = '0;
    for (int b = 0; b < NB; b++)
      if (!def_m) v[b*SW +: SW] = SW'(sat(is_cut ? cut_m[b] : boost_m[b]));
    return v;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      boost_m[b] = 0;
      cut_m[b]   = 0;
    end
    def_m = 1'b1;
  endtask

  task automatic model_apply(input int p, input logic [7:0] d);
    if (p < NB) begin
      boost_m[p] = int'(d[6:4]);
      cut_m[p]   = int'(d[2:0]);
      if (p == 0) def_m = d[7];
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // continuous comparison against the reference model (R6, R7)
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      checks++;
      if (boost !== exp_vec(1'b0) || cut !== exp_vec(1'b1) || defeat !== def_m) begin
        fails++;
        $display("FAIL R6 R7 outputs boost=%h/%h cut=%h/%h defeat=%b/%b (actual/expected)",
                 boost, exp_vec(1'b0), cut, exp_vec(1'b1), defeat, def_m);
      end
    end
  end

  task automatic wait_h();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_h();
    scl_m = 1'b1; wait_h();
    sda_m = 1'b0; wait_h();
    scl_m = 1'b0; wait_h();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h();
    scl_m = 1'b1; wait_h();
    sda_m = 1'b1; wait_h();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_h();
      scl_m = 1'b1; wait_h();
      scl_m = 1'b0; wait_h();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    send_bits(b, 8);
    sda_m = 1'b1; wait_h();
    scl_m = 1'b1; wait_h();
    check(sda_pull === exp_ack, req, int'(sda_pull), int'(exp_ack));
    scl_m = 1'b0; wait_h();
  endtask

  task automatic do_write(input logic [7:0] abyte, input bit ok, input int sub, input int n);
    int p;
    string req;
    if (ok) cmp_en = 1'b0;
    bus_start();
    send_byte(abyte, ok, ok ? "R1" : "R2");
    send_byte(8'(sub), ok, ok ? "R3" : "R2");
    p = sub;
    for (int i = 0; i < n; i++) begin
      if (!ok)          req = "R2";
      else if (p >= NB) req = "R5";
      else if (i > 0)   req = "R4";
      else              req = "R3";
      send_byte(pay[i], ok, req);
      if (ok) model_apply(p, pay[i]);
      if (p < 255) p++;
    end
    bus_stop();
    wait_h();
    cmp_en = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    // R8: reset state
    check(defeat === 1'b1, "R8", int'(defeat), 1);
    check(boost === '0 && cut === '0, "R8", int'(boost | cut), 0);
    check(sda_pull === 1'b0, "R8", int'(sda_pull), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;

    // R1 R3: clear defeat, band 1 boost 2 cut 1
    pay[0] = 8'h21;
    do_write(8'h84, 1'b1, 0, 1);
    check(defeat === 1'b0, "R3", int'(defeat), 0);
    check(boost[2:0] === 3'd2 && cut[2:0] === 3'd1, "R3", int'(boost[2:0]), 2);

    // R4 R6: bands 2..5 in one burst, saturating codes
    pay[0] = 8'h50; pay[1] = 8'h67; pay[2] = 8'h7C; pay[3] = 8'h46;
    do_write(8'h84, 1'b1, 1, 4);
    check(boost[5:3] === 3'd5, "R6", int'(boost[5:3]), 5);
    check(cut[8:6] === 3'd5 && boost[8:6] === 3'd5, "R6", int'(cut[8:6]), 5);
    check(boost[14:12] === 3'd4 && cut[14:12] === 3'd5, "R4", int'(boost[14:12]), 4);

    // R5: auto-increment past band 5 and a direct far subaddress
    pay[0] = 8'h13; pay[1] = 8'h31; pay[2] = 8'h77; pay[3] = 8'h55;
    do_write(8'h84, 1'b1, 3, 4);
    pay[0] = 8'h77;
    do_write(8'h84, 1'b1, 7, 1);
    check(boost[14:12] === 3'd3 && cut[14:12] === 3'd1, "R5", int'(boost[14:12]), 3);

    // R2: wrong address and read request are ignored
    pay[0] = 8'h00; pay[1] = 8'h44;
    do_write(8'h86, 1'b0, 0, 2);
    do_write(8'h85, 1'b0, 0, 2);
    check(defeat === 1'b0, "R2", int'(defeat), 0);

    // R1: strap high moves the address
    sel = 1'b1;
    repeat (5) @(negedge clk);
    do_write(8'h84, 1'b0, 2, 1);
    pay[0] = 8'h22;
    do_write(8'h86, 1'b1, 2, 1);
    check(boost[8:6] === 3'd2, "R1", int'(boost[8:6]), 2);
    sel = 1'b0;
    repeat (5) @(negedge clk);

    // R7: defeat flattens, settings kept and restored
    pay[0] = 8'hB3;
    do_write(8'h84, 1'b1, 0, 1);
    check(boost === '0 && cut === '0 && defeat === 1'b1, "R7", int'(boost), 0);
    pay[0] = 8'h12;
    do_write(8'h84, 1'b1, 0, 1);
    check(boost[5:3] === 3'd5 && boost[8:6] === 3'd2, "R7", int'(boost[5:3]), 5);

    // R9: STOP in the middle of a data byte
    bus_start();
    send_byte(8'h84, 1'b1, "R9");
    send_byte(8'h01, 1'b1, "R9");
    send_bits(8'h00, 5);
    bus_stop();
    wait_h();
    check(boost[5:3] === 3'd5, "R9", int'(boost[5:3]), 5);

    // R10: repeated START mid-byte and after a byte
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'h84, 1'b1, "R10");
    send_byte(8'h02, 1'b1, "R10");
    send_bits(8'h00, 3);
    bus_start();
    send_byte(8'h84, 1'b1, "R10");
    send_byte(8'h04, 1'b1, "R10");
    send_byte(8'h25, 1'b1, "R10");
    model_apply(4, 8'h25);
    bus_start();
    send_byte(8'h84, 1'b1, "R10");
    send_byte(8'h02, 1'b1, "R10");
    send_byte(8'h33, 1'b1, "R10");
    model_apply(2, 8'h33);
    bus_stop();
    wait_h();
    cmp_en = 1'b1;
    check(boost[14:12] === 3'd2 && cut[14:12] === 3'd5, "R10", int'(boost[14:12]), 2);
    check(boost[8:6] === 3'd3 && cut[8:6] === 3'd3, "R10", int'(boost[8:6]), 3);

    // R8: reset in mid-run restores defaults
    cmp_en = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check(defeat === 1'b1 && sda_pull === 1'b0, "R8", int'(defeat), 1);
    cmp_en = 1'b1;
    pay[0] = 8'h00;
    do_write(8'h84, 1'b1, 0, 1);
    check(boost === '0 && cut === '0 && defeat === 1'b0, "R8", int'(boost | cut), 0);

    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule